// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block holds the program counter of a core with fixed-width 32-bit instructions and works out its next value. In each cycle it takes the instruction word fetched at the current PC and the two register operands read for that instruction. The instruction selects the next PC from one of these sources: the next sequential word, a relative branch target, an absolute jump target, or a register value. The PC register loads the chosen value on the next rising clock edge.

For call instructions the block also issues a register write request that saves the return address. Arithmetic, memory access, delay slots, hazards and exceptions are handled elsewhere. The surrounding datapath uses the link request as one more write port request into its register file.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset loads `pc_o` with 0x00000000. After reset is released, the first instruction is taken from address 0.
- R2: An instruction whose opcode (bits 31:26) is not 000000, 000010, 000011, 000100 or 000101 sets `next_pc_o` to `pc_o + 4`.
- R3: For opcode 000100 (branch if equal), the branch is taken when `rs_val_i == rt_val_i`, and `next_pc_o` is `pc_o + 4 + (sign-extended bits 15:0 shifted left by 2)`. When the operands differ, `next_pc_o` is `pc_o + 4`.
- R4: For opcode 000101 (branch if not equal), the branch is taken when the operands differ, using the same target. When the operands are equal, `next_pc_o` is `pc_o + 4`. Operands that differ only in bit 31 count as different.
- R5: The 16-bit branch offset is signed over its full range. 0x7FFF gives +0x1FFFC bytes from `pc_o + 4`, 0x8000 gives -0x20000 bytes, and 0xFFFD gives -12 bytes.
- R6: For opcode 000010 (jump), `next_pc_o` is the concatenation of bits 31:28 of `pc_o + 4`, instruction bits 25:0 and two zero bits.
- R7: For opcode 000011 (call), `next_pc_o` is formed as in R6. `link_we_o` is 1 and `link_data_o` is `pc_o + 4`.
- R8: Opcode 000000 with function field (bits 5:0) 001000 sets `next_pc_o` to `rs_val_i`, with all 32 bits kept. Opcode 000000 with any other function field sets `next_pc_o` to `pc_o + 4`.
- R9: `link_we_o` is 0 for every instruction other than the call. `link_idx_o` always reads 31, and `link_data_o` always equals `pc_o + 4`.
- R10: While reset is low, `pc_o` after each rising clock edge equals the `next_pc_o` presented before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | PC to be loaded at the next edge |
| link_we_o | output | 1 | Return-address write request |
| link_idx_o | output | 5 | Register index for the return address |
| link_data_o | output | 32 | Return address value |

## Verification
A call instruction changes control flow and requests a register write in the same cycle. The jump target and the link value both come from one shared `pc_o + 4`. The bench therefore places calls at PCs whose upper nibble is non-zero, so a wrong bit slice in either path shows up. Each call is judged on three things: the link write enable, the link data read before the clock edge, and the PC loaded after the edge. Branches with operands that differ only in bit 31 are also placed next to jumps, so that a comparison error shows up as a wrong target in the scoreboard.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;

   localparam int OPC_W   = 6;
   localparam int FUNCT_W = 6;

   localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'b000000;
   localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'b000010;
   localparam logic [OPC_W-1:0]   OPC_CALL    = 6'b000011;
   localparam logic [OPC_W-1:0]   OPC_BR_EQ   = 6'b000100;
   localparam logic [OPC_W-1:0]   OPC_BR_NE   = 6'b000101;
   localparam logic [FUNCT_W-1:0] FN_JREG     = 6'b001000;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BR_EQ,
      FLOW_BR_NE,
      FLOW_JUMP,
      FLOW_CALL,
      FLOW_JREG
   } flow_e;

endpackage

// File: rtl/pcu_decode.sv
`timescale 1ns/1ps
module pcu_decode
   import pcu_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter int JADDR_W = 26
) (
   input  logic [XLEN-1:0]    instr_i,
   output flow_e              flow_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic [JADDR_W-1:0] jaddr_o
);

   localparam int MID_W = JADDR_W - IMM_W - FUNCT_W;

   logic [OPC_W-1:0]   opcode;
   logic [FUNCT_W-1:0] funct;
   logic [MID_W-1:0]   mid_unused;

   assign opcode  = instr_i[XLEN-1 -: OPC_W];
   assign funct   = instr_i[FUNCT_W-1:0];
   assign imm_o   = instr_i[IMM_W-1:0];
   assign jaddr_o = instr_i[JADDR_W-1:0];
   // register fields are consumed by the operand read path, not here
   assign mid_unused = instr_i[JADDR_W-1 -: MID_W];

   always_comb begin
      flow_o = FLOW_SEQ;
      unique case (opcode)
         OPC_BR_EQ:   flow_o = FLOW_BR_EQ;
         OPC_BR_NE:   flow_o = FLOW_BR_NE;
         OPC_JUMP:    flow_o = FLOW_JUMP;
         OPC_CALL:    flow_o = FLOW_CALL;
         OPC_SPECIAL: flow_o = (funct == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
         default:     flow_o = FLOW_SEQ;
      endcase
   end

   logic mid_sink;
   assign mid_sink = ^mid_unused;

   logic unused_ok;
   assign unused_ok = mid_sink | 1'b1;

endmodule

// File: rtl/pcu_compare.sv
`timescale 1ns/1ps
module pcu_compare #(
   parameter int XLEN      = 32,
   parameter bit XOR_STYLE = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o
);

   generate
      if (XOR_STYLE) begin : g_xor
         logic [XLEN-1:0] diff;
         assign diff = a_i ^ b_i;
         assign eq_o = ~|diff;
      end else begin : g_direct
         assign eq_o = (a_i == b_i);
      end
   endgenerate

endmodule

// File: rtl/pcu_target.sv
`timescale 1ns/1ps
module pcu_target #(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter int JADDR_W = 26
) (
   input  logic [XLEN-1:0]    pc_i,
   input  logic [IMM_W-1:0]   imm_i,
   input  logic [JADDR_W-1:0] jaddr_i,
   output logic [XLEN-1:0]    seq_pc_o,
   output logic [XLEN-1:0]    br_pc_o,
   output logic [XLEN-1:0]    jmp_pc_o
);

   localparam int WORD_SH = 2;
   localparam int EXT_W   = XLEN - IMM_W - WORD_SH;
   localparam int HI_W    = XLEN - JADDR_W - WORD_SH;
   localparam logic [XLEN-1:0] STEP = XLEN'(1 << WORD_SH);

   logic [XLEN-1:0] offset_bytes;

   assign seq_pc_o     = pc_i + STEP;
   assign offset_bytes = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {WORD_SH{1'b0}}};
   assign br_pc_o      = seq_pc_o + offset_bytes;
   assign jmp_pc_o     = {seq_pc_o[XLEN-1 -: HI_W], jaddr_i, {WORD_SH{1'b0}}};

endmodule

// File: rtl/pcu_pc_reg.sv
`timescale 1ns/1ps
module pcu_pc_reg #(
   parameter int              XLEN     = 32,
   parameter logic [XLEN-1:0] RESET_PC = '0
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic [XLEN-1:0] d_i,
   output logic [XLEN-1:0] q_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) q_o <= RESET_PC;
      else       q_o <= d_i;
   end

endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
   import pcu_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              IMM_W     = 16,
   parameter int              REG_IDX_W = 5,
   parameter int              LINK_REG  = 31,
   parameter logic [XLEN-1:0] RESET_PC  = '0,
   parameter bit              CMP_XOR   = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [XLEN-1:0]      instr_i,
   input  logic [XLEN-1:0]      rs_val_i,
   input  logic [XLEN-1:0]      rt_val_i,
   output logic [XLEN-1:0]      pc_o,
   output logic [XLEN-1:0]      next_pc_o,
   output logic                 link_we_o,
   output logic [REG_IDX_W-1:0] link_idx_o,
   output logic [XLEN-1:0]      link_data_o
);

   localparam int JADDR_W = XLEN - OPC_W;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("pc_sequencer: instruction format needs XLEN of 32");
      end
      if (IMM_W + 2 >= XLEN) begin : g_bad_imm
         $error("pc_sequencer: IMM_W too wide for XLEN");
      end
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("pc_sequencer: LINK_REG does not fit REG_IDX_W");
      end
   endgenerate

   flow_e              flow;
   logic [IMM_W-1:0]   imm;
   logic [JADDR_W-1:0] jaddr;
   logic               ops_eq;
   logic [XLEN-1:0]    seq_pc;
   logic [XLEN-1:0]    br_pc;
   logic [XLEN-1:0]    jmp_pc;
   logic [XLEN-1:0]    pc_q;
   logic [XLEN-1:0]    pc_d;

   pcu_decode #(.XLEN(XLEN), .IMM_W(IMM_W), .JADDR_W(JADDR_W)) u_decode (
      .instr_i (instr_i),
      .flow_o  (flow),
      .imm_o   (imm),
      .jaddr_o (jaddr)
   );

   pcu_compare #(.XLEN(XLEN), .XOR_STYLE(CMP_XOR)) u_compare (
      .a_i  (rs_val_i),
      .b_i  (rt_val_i),
      .eq_o (ops_eq)
   );

   pcu_target #(.XLEN(XLEN), .IMM_W(IMM_W), .JADDR_W(JADDR_W)) u_target (
      .pc_i     (pc_q),
      .imm_i    (imm),
      .jaddr_i  (jaddr),
      .seq_pc_o (seq_pc),
      .br_pc_o  (br_pc),
      .jmp_pc_o (jmp_pc)
   );

   always_comb begin
      pc_d = seq_pc;
      unique case (flow)
         FLOW_BR_EQ: pc_d = ops_eq ? br_pc : seq_pc;
         FLOW_BR_NE: pc_d = ops_eq ? seq_pc : br_pc;
         FLOW_JUMP:  pc_d = jmp_pc;
         FLOW_CALL:  pc_d = jmp_pc;
         FLOW_JREG:  pc_d = rs_val_i;
         default:    pc_d = seq_pc;
      endcase
   end

   pcu_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (pc_d),
      .q_o   (pc_q)
   );

   assign pc_o        = pc_q;
   assign next_pc_o   = pc_d;
   assign link_we_o   = (flow == FLOW_CALL);
   assign link_idx_o  = REG_IDX_W'(LINK_REG);
   assign link_data_o = seq_pc;

endmodule

// File: rtl/pcu_checker.sv
`timescale 1ns/1ps
module pcu_checker #(
   parameter int              XLEN      = 32,
   parameter int              REG_IDX_W = 5,
   parameter logic [XLEN-1:0] RESET_PC  = '0
) (
   input logic                 clk_i,
   input logic                 rst_i,
   input logic [XLEN-1:0]      instr_i,
   input logic [XLEN-1:0]      rs_val_i,
   input logic [XLEN-1:0]      rt_val_i,
   input logic [XLEN-1:0]      pc_o,
   input logic [XLEN-1:0]      next_pc_o,
   input logic                 link_we_o,
   input logic [REG_IDX_W-1:0] link_idx_o,
   input logic [XLEN-1:0]      link_data_o
);

   logic [5:0]      op;
   logic [5:0]      fn;
   logic [XLEN-1:0] pc_plus;
   logic            ctl_op;

   assign op      = instr_i[XLEN-1 -: 6];
   assign fn      = instr_i[5:0];
   assign pc_plus = pc_o + XLEN'(4);
   assign ctl_op  = (op == 6'd0) || (op == 6'd2) || (op == 6'd3) ||
                    (op == 6'd4) || (op == 6'd5);

   // R1
   rst_pc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> pc_o == RESET_PC);

   // R10
   pc_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> pc_o == $past(next_pc_o));

   // R2
   seq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !ctl_op |-> next_pc_o == pc_plus);

   // R3
   beq_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op == 6'd4 && rs_val_i != rt_val_i) |-> next_pc_o == pc_plus);

   // R6
   jmp_form_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op == 6'd2) |-> (next_pc_o[1:0] == 2'b00 &&
                        next_pc_o[XLEN-1 -: 4] == pc_plus[XLEN-1 -: 4]));

   // R7
   call_link_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      link_we_o |-> (op == 6'd3 && link_data_o == pc_plus && link_idx_o == REG_IDX_W'(31)));

   // R8
   jreg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (op == 6'd0 && fn == 6'b001000) |-> next_pc_o == rs_val_i);

endmodule

bind pc_sequencer pcu_checker #(
   .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .RESET_PC(RESET_PC)
) u_pcu_checker (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .instr_i     (instr_i),
   .rs_val_i    (rs_val_i),
   .rt_val_i    (rt_val_i),
   .pc_o        (pc_o),
   .next_pc_o   (next_pc_o),
   .link_we_o   (link_we_o),
   .link_idx_o  (link_idx_o),
   .link_data_o (link_data_o)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

   typedef struct {
      logic [31:0] npc;
      logic        we;
      logic [31:0] ldata;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = 32'h0;
   logic [31:0] rs_v = 32'h0;
   logic [31:0] rt_v = 32'h0;
   logic [31:0] pc, npc, ldata;
   logic        lwe;
   logic [4:0]  lidx;

   int checks = 0;
   int errors = 0;
   logic [31:0] model_pc = 32'h0;
   item_t sb[$];

   always #2.5 clk = ~clk;

   pc_sequencer i_pc_sequencer (
      .clk_i (clk), .rst_i (rst), .instr_i (instr),
      .rs_val_i (rs_v), .rt_val_i (rt_v),
      .pc_o (pc), .next_pc_o (npc), .link_we_o (lwe),
      .link_idx_o (lidx), .link_data_o (ldata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
      return {op, 5'd1, 5'd2, imm};
   endfunction

   function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] a);
      return {op, a};
   endfunction

   // expected next PC, written from the requirement list
   function automatic logic [31:0] expect_next(input logic [31:0] ins, input logic [31:0] a,
                                               input logic [31:0] b, input logic [31:0] p);
      logic [31:0] p4;
      logic [31:0] off;
      p4  = p + 32'd4;
      off = 32'(signed'(ins[15:0])) * 32'd4;
      case (ins[31:26])
         6'd4:    return (a == b) ? p4 + off : p4;
         6'd5:    return (a != b) ? p4 + off : p4;
         6'd2,
         6'd3:    return {p4[31:28], ins[25:0], 2'b00};
         6'd0:    return (ins[5:0] == 6'h08) ? a : p4;
         default: return p4;
      endcase
   endfunction

   task automatic issue(input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input string req);
      item_t it;
      instr = ins; rs_v = a; rt_v = b;
      it.npc   = expect_next(ins, a, b, model_pc);
      it.we    = (ins[31:26] == 6'd3);
      it.ldata = model_pc + 32'd4;
      it.req   = req;
      model_pc = it.npc;
      sb.push_back(it);
      @(posedge clk); #0.5;
   endtask

   // monitor: link and next-PC before the edge, loaded PC after it
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb[0];
            check(npc === it.npc, it.req, npc, it.npc);
            check(lwe === it.we, {it.req, "/R9 link_we"}, 32'(lwe), 32'(it.we));
            check(ldata === it.ldata, {it.req, "/R9 link_data"}, ldata, it.ldata);
            check(lidx === 5'd31, "R9 link_idx", 32'(lidx), 32'd31);
            @(posedge clk); #0.2;
            check(pc === it.npc, {it.req, "/R10 pc load"}, pc, it.npc);
            void'(sb.pop_front());
         end
      end
   end

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #0.5;
      check(pc === 32'h0, "R1 reset pc", pc, 32'h0);
      rst = 1'b0;
      model_pc = 32'h0;
      issue(32'h012A4020, 32'h5, 32'h6, "R2 alu op");
      issue(enc_i(6'd4, 16'd3), 32'h55, 32'h55, "R3 beq taken");
      issue(enc_i(6'd4, 16'd3), 32'h1, 32'h2, "R3 beq not taken");
      issue(enc_i(6'd5, 16'hFFFD), 32'h1, 32'h2, "R4 R5 bne back");
      issue(enc_i(6'd5, 16'h0040), 32'h7, 32'h7, "R4 bne not taken");
      issue(enc_j(6'd2, 26'h40), 32'h0, 32'h0, "R6 jump");
      issue(enc_j(6'd3, 26'h80), 32'h0, 32'h0, "R7 call");
      issue({6'd0, 5'd4, 15'd0, 6'h08}, 32'hA0000010, 32'h0, "R8 jreg");
      issue({6'd0, 5'd4, 15'd0, 6'h20}, 32'h12345678, 32'h0, "R8 other funct");
      issue(enc_j(6'd2, 26'h3FFFFFF), 32'h0, 32'h0, "R6 jump upper bits");
      issue(enc_i(6'd4, 16'h7FFF), 32'h9, 32'h9, "R5 max offset");
      issue(enc_i(6'd4, 16'h8000), 32'h9, 32'h9, "R5 min offset");
      issue(enc_j(6'd3, 26'h1234567), 32'h0, 32'h0, "R7 call high page");
      issue(enc_i(6'h23, 16'h0010), 32'h3, 32'h3, "R2 load op");
      issue(enc_i(6'd5, 16'h0004), 32'h80000000, 32'h0, "R4 bit31 diff");
      issue(enc_i(6'd4, 16'h0004), 32'h80000000, 32'h0, "R3 bit31 diff");
      wait (sb.size() == 0);
      rst = 1'b1;
      @(posedge clk); #0.5;
      check(pc === 32'h0, "R1 mid-run reset", pc, 32'h0);
      @(posedge clk); #0.5;
      rst = 1'b0;
      model_pc = 32'h0;
      issue(enc_j(6'd3, 26'h10), 32'h0, 32'h0, "R7 call after reset");
      issue(enc_i(6'd8, 16'h0001), 32'h0, 32'h0, "R2 addi op");
      wait (sb.size() == 0);
      #10;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule